// File: doc/BRIEF.md
# Reloading Interval Timer

A single down-counting interval timer driven by the system clock. Software loads a reload value into a latch over a narrow register bus, then writes a control byte to start it. While running, the counter steps down once per clock. When it reaches the end of its count it reloads from the latch on its own and raises an interrupt flag, so the interrupt arrives at a fixed period equal to the reload value (for example 8×63 = 504 cycles) without any software action.

Counting does not begin on the clock after the start write. It begins a fixed number of cycles later, three by default. In continuous mode the counter is never seen at zero: on the clock where zero would appear, the reloaded value is already in place. The timer can be stopped and restarted at any time, so it can be realigned to an outside event. A one-shot mode stops it after one underflow. A force-load strobe copies the latch into the counter at once. A read-to-clear status register and a mask bit drive an active-low interrupt output.

Register map (byte addresses, 8-bit data): 0 and 1 read the counter low and high bytes and write the latch low and high bytes. 2 is control: bit0 run, bit1 one-shot, bit2 force-load. 3 is status: bit0 is the underflow flag. 4 is the interrupt mask in bit0.

Top module: `reload_timer`

## Requirements
- R1: In continuous mode (control bit1 = 0), a decrement from 1 loads the latch value L into the counter instead of 0, so the counter runs with a period of exactly L cycles (L >= 1), including L = 504.
- R2: Every underflow sets the status flag (bit0 of address 3) on the same clock edge that performs the reload.
- R3: After a control write that sets the run bit (bit0) while the timer is stopped, the counter keeps its value, and its first decrement happens on the 3rd rising edge after the write edge (START_DLY, default 3).
- R4: While counting down from a nonzero latch value, a read of the counter (addresses 0 and 1) never returns zero.
- R5: Writing control with bit0 = 0 freezes the counter at its value. Setting bit0 again restarts counting with the R3 delay.
- R6: In one-shot mode (control bit1 = 1), an underflow reloads the counter from the latch and clears the run bit, so the counter then holds the reload value.
- R7: A control write with bit2 = 1 copies the latch into the counter on that write edge. Bit2 always reads back as 0. After reset the counter and the latch hold all ones, control reads 0, and the status flag is 0.
- R8: Writes to the latch (address 0 low byte, address 1 high byte) while running do not change the current count. The new value is used at the next reload.
- R9: A read of address 3 returns the flag in bit0 and clears it on that edge, unless an underflow sets it on the same edge. irq_no is 0 exactly when the flag and the mask (address 4 bit0) are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, also the count clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W (3) | Register address |
| wdata_i | input | BUS_W (8) | Write data |
| wr_i | input | 1 | Write strobe, one cycle per access |
| rd_i | input | 1 | Read strobe, needed only for the clear-on-read status |
| rdata_o | output | BUS_W (8) | Read data, combinational from addr_i |
| irq_no | output | 1 | Active-low interrupt request |

## Verification
Read data is combinational, so each register result is due at the first falling edge after the edge that changed the state. The bench samples every result there. The bench counts rising edges from the start write: the count must hold through the edges numbered 1 and 2 and first decrement on edge 3. After that, the value on the k-th edge after the second edge is L − (k mod L), with 0 replaced by L. The flag and irq_no must change on the same edge as the reload. A status read clears the flag on the edge of that read. Sweeps over reload values 1 to 12 and 504 check every cycle against this formula, and directed runs cover stop and restart, one-shot, force-load, a latch write during counting, and the mask.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;
  typedef enum logic [2:0] {SEL_CNT, SEL_CTRL, SEL_STAT, SEL_MASK, SEL_NONE} sel_e;
  localparam int unsigned CB_RUN     = 0;
  localparam int unsigned CB_ONESHOT = 1;
  localparam int unsigned CB_FORCE   = 2;
endpackage

// File: rtl/rtimer_regs.sv
module rtimer_regs
  import rtimer_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned BUS_W  = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              flag_i,
  input  logic              mask_i,
  input  logic              underflow_i,
  output logic [CNT_W-1:0]  latch_o,
  output logic              run_o,
  output logic              oneshot_o,
  output logic              start_o,
  output logic              force_o,
  output logic              stat_rd_o,
  output logic              mask_wr_o,
  output logic [BUS_W-1:0]  rdata_o
);
  localparam int unsigned NB = CNT_W / BUS_W;
  localparam int unsigned LW = (NB > 1) ? $clog2(NB) : 1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NB);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NB + 1);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(NB + 2);

  sel_e                  sel;
  logic                  ctrl_wr;
  logic                  run_q, oneshot_q;
  logic [NB-1:0][BUS_W-1:0] latch_q;
  logic [BUS_W-1:0]      cnt_lane [NB];
  logic [LW-1:0]         lane_idx;

  always_comb begin
    if (addr_i < A_CTRL)       sel = SEL_CNT;
    else if (addr_i == A_CTRL) sel = SEL_CTRL;
    else if (addr_i == A_STAT) sel = SEL_STAT;
    else if (addr_i == A_MASK) sel = SEL_MASK;
    else                       sel = SEL_NONE;
  end

  assign ctrl_wr  = wr_i && (sel == SEL_CTRL);
  assign lane_idx = addr_i[LW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '1;
    end else if (wr_i && sel == SEL_CNT) begin
      for (int b = 0; b < int'(NB); b++)
        if (lane_idx == LW'(b)) latch_q[b] <= wdata_i;
    end
  end

  // control write wins over one-shot self clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      oneshot_q <= 1'b0;
    end else if (ctrl_wr) begin
      run_q     <= wdata_i[CB_RUN];
      oneshot_q <= wdata_i[CB_ONESHOT];
    end else if (underflow_i && oneshot_q) begin
      run_q     <= 1'b0;
    end
  end

  generate
    for (genvar g = 0; g < int'(NB); g++) begin : g_lane
      assign cnt_lane[g] = count_i[g*BUS_W +: BUS_W];
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    unique case (sel)
      SEL_CNT:  rdata_o = cnt_lane[lane_idx];
      SEL_CTRL: begin
        rdata_o[CB_RUN]     = run_q;
        rdata_o[CB_ONESHOT] = oneshot_q;
      end
      SEL_STAT: rdata_o[0] = flag_i;
      SEL_MASK: rdata_o[0] = mask_i;
      default:  rdata_o = '0;
    endcase
  end

  assign latch_o   = latch_q;
  assign run_o     = run_q;
  assign oneshot_o = oneshot_q;
  assign start_o   = ctrl_wr && wdata_i[CB_RUN] && !run_q;
  assign force_o   = ctrl_wr && wdata_i[CB_FORCE];
  assign stat_rd_o = rd_i && (sel == SEL_STAT);
  assign mask_wr_o = wr_i && (sel == SEL_MASK);
endmodule

// File: rtl/rtimer_count.sv
module rtimer_count #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned START_DLY = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             start_i,
  input  logic             force_i,
  input  logic [CNT_W-1:0] latch_i,
  output logic [CNT_W-1:0] count_o,
  output logic             underflow_o,
  output logic             en_o,
  output logic             busy_o
);
  localparam int unsigned DW = $clog2(START_DLY + 1);

  logic [DW-1:0]    dly_q;
  logic [CNT_W-1:0] count_q;
  logic             en, uf;

  // arm delay: first decrement lands START_DLY edges after the start edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             dly_q <= '0;
    else if (start_i)        dly_q <= DW'(START_DLY - 1);
    else if (dly_q != '0)    dly_q <= dly_q - 1'b1;
  end

  assign en = run_i && (dly_q == '0) && !start_i;
  // reload replaces the step to zero, so zero is never visible
  assign uf = en && (count_q <= CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      count_q <= '1;
    else if (force_i) count_q <= latch_i;
    else if (uf)      count_q <= latch_i;
    else if (en)      count_q <= count_q - 1'b1;
  end

  assign count_o     = count_q;
  assign underflow_o = uf;
  assign en_o        = en;
  assign busy_o      = (dly_q != '0);
endmodule

// File: rtl/rtimer_irq.sv
module rtimer_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic underflow_i,
  input  logic clr_i,
  input  logic mask_wr_i,
  input  logic mask_d_i,
  output logic flag_o,
  output logic mask_o,
  output logic irq_no
);
  logic flag_q, mask_q;

  // a new underflow beats a clearing read on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          flag_q <= 1'b0;
    else if (underflow_i) flag_q <= 1'b1;
    else if (clr_i)       flag_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= 1'b0;
    else if (mask_wr_i) mask_q <= mask_d_i;
  end

  assign flag_o = flag_q;
  assign mask_o = mask_q;
  assign irq_no = !(flag_q && mask_q);
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned BUS_W     = 8,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned START_DLY = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              wr_i,
  input  logic              rd_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              irq_no
);
  logic [CNT_W-1:0] count_w, latch_w;
  logic run_w, oneshot_w, start_w, force_w, stat_rd_w, mask_wr_w;
  logic uf_w, en_w, busy_w, flag_w, mask_w;

  rtimer_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .count_i(count_w), .flag_i(flag_w),
    .mask_i(mask_w), .underflow_i(uf_w), .latch_o(latch_w), .run_o(run_w),
    .oneshot_o(oneshot_w), .start_o(start_w), .force_o(force_w),
    .stat_rd_o(stat_rd_w), .mask_wr_o(mask_wr_w), .rdata_o(rdata_o)
  );

  rtimer_count #(.CNT_W(CNT_W), .START_DLY(START_DLY)) u_count (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_w), .start_i(start_w),
    .force_i(force_w), .latch_i(latch_w), .count_o(count_w),
    .underflow_o(uf_w), .en_o(en_w), .busy_o(busy_w)
  );

  rtimer_irq u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .underflow_i(uf_w), .clr_i(stat_rd_w),
    .mask_wr_i(mask_wr_w), .mask_d_i(wdata_i[0]), .flag_o(flag_w),
    .mask_o(mask_w), .irq_no(irq_no)
  );
endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic [CNT_W-1:0] count_i,
  input logic [CNT_W-1:0] latch_i,
  input logic             uf_i,
  input logic             en_i,
  input logic             busy_i,
  input logic             force_i,
  input logic             run_i,
  input logic             oneshot_i,
  input logic             flag_i,
  input logic             irq_no_i
);
  a_r1_reload_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_i && !force_i |=> count_i == $past(latch_i));

  a_r2_flag_on_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_i |=> flag_i);

  a_r3_hold_while_arming: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !force_i |=> $stable(count_i));

  a_r4_never_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && latch_i != '0 |=> count_i != '0);

  a_r5_stopped_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !force_i |=> $stable(count_i));

  a_r6_oneshot_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uf_i && oneshot_i && !wr_i |=> !run_i);

  a_r9_quiet_without_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_i |-> irq_no_i);
endmodule

bind reload_timer reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .count_i(count_w),
  .latch_i(latch_w), .uf_i(uf_w), .en_i(en_w), .busy_i(busy_w),
  .force_i(force_w), .run_i(run_w), .oneshot_i(oneshot_w),
  .flag_i(flag_w), .irq_no_i(irq_no)
);

// File: tb/reload_timer_test.sv
module reload_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int A_CTRL = 2;
  localparam int A_STAT = 3;
  localparam int A_MASK = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic       wr_i = 1'b0;
  logic       rd_i = 1'b0;
  logic [7:0] rdata_o;
  logic       irq_no;

  int n_chk = 0;
  int n_fail = 0;

  reload_timer uut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .wr_i(wr_i), .rd_i(rd_i), .rdata_o(rdata_o), .irq_no(irq_no)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    addr_i = 3'(a); wdata_i = d; wr_i = 1'b1;
    @(posedge clk); @(negedge clk);
    wr_i = 1'b0;
  endtask

  task automatic peek_cnt(output logic [15:0] v);
    addr_i = 3'd0; #1 v[7:0] = rdata_o;
    addr_i = 3'd1; #1 v[15:8] = rdata_o;
  endtask

  task automatic peek_reg(input int a, output logic [7:0] v);
    addr_i = 3'(a); #1 v = rdata_o;
  endtask

  task automatic rd_stat(output logic v);
    addr_i = 3'(A_STAT); rd_i = 1'b1; #1 v = rdata_o[0];
    @(posedge clk); @(negedge clk);
    rd_i = 1'b0;
  endtask

  task automatic load_count(input logic [15:0] v);
    logic s;
    wr(0, v[7:0]);
    wr(1, v[15:8]);
    wr(A_CTRL, 8'h04);   // force-load, run cleared
    rd_stat(s);
  endtask

  // continuous run, sampled every cycle: value after edge (2+k) is L-(k mod L)
  task automatic sweep(input int L);
    logic [15:0] v;
    load_count(16'(L));
    wr(A_CTRL, 8'h01);
    for (int k = -2; k <= 3*L + 1; k++) begin
      peek_cnt(v);
      if (k <= 0) check("R3 hold before first decrement", v, 32'(L));
      else begin
        check("R4 count sequence", v, 32'(L - (k % L)));
        check("R4 never zero", 32'(v != 0), 1);
        if (k % L == 0) check("R1 reload at period", v, 32'(L));
      end
      check("R2 irq after first underflow", irq_no, (k >= L) ? 0 : 1);
      @(negedge clk);
    end
    wr(A_CTRL, 8'h00);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v, v0;
    logic [7:0]  r;
    logic        s;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // reset state
    peek_cnt(v);         check("R7 reset counter", v, 32'hFFFF);
    peek_reg(A_CTRL, r); check("R7 reset control", r, 0);
    peek_reg(A_STAT, r); check("R7 reset flag", r, 0);
    check("R9 reset irq", irq_no, 1);

    wr(A_MASK, 8'h01);
    for (int L = 1; L <= 12; L++) sweep(L);
    sweep(504);

    // status read-clear
    rd_stat(s); check("R9 status read returns flag", s, 1);
    check("R9 irq released after clear", irq_no, 1);
    rd_stat(s); check("R9 status cleared", s, 0);

    // stop and restart
    load_count(16'd100);
    wr(A_CTRL, 8'h01);
    repeat (10) @(negedge clk);
    wr(A_CTRL, 8'h00);
    peek_cnt(v0);
    repeat (4) @(negedge clk);
    peek_cnt(v); check("R5 stopped counter frozen", v, 32'(v0));
    wr(A_CTRL, 8'h01);
    for (int k = -2; k <= 2; k++) begin
      peek_cnt(v);
      check("R5 restart with delay", v, (k <= 0) ? 32'(v0) : 32'(v0) - 32'(k));
      @(negedge clk);
    end
    wr(A_CTRL, 8'h00);

    // one-shot
    load_count(16'd4);
    wr(A_CTRL, 8'h03);
    for (int k = -2; k <= 8; k++) begin
      peek_cnt(v);
      check("R6 one-shot count", v, (k <= 0 || k >= 4) ? 4 : 32'(4 - k));
      peek_reg(A_CTRL, r);
      check("R6 run bit", r[0], (k >= 4) ? 0 : 1);
      @(negedge clk);
    end

    // force-load
    load_count(16'h1234);
    peek_cnt(v); check("R7 force copies latch", v, 32'h1234);
    peek_reg(A_CTRL, r); check("R7 force bit reads zero", r[2], 0);

    // latch write while running
    load_count(16'd10);
    wr(A_CTRL, 8'h01);
    for (int k = -2; k <= 12; k++) begin
      wr_i = 1'b0;
      peek_cnt(v);
      check("R8 latch write affects next reload only", v,
            (k <= 0) ? 10 : (k < 10) ? 32'(10 - k) : 32'(30 - k));
      if (k == 3) begin addr_i = 3'd0; wdata_i = 8'd20; wr_i = 1'b1; end
      if (k == 4) begin addr_i = 3'd1; wdata_i = 8'd0;  wr_i = 1'b1; end
      @(negedge clk);
    end
    wr_i = 1'b0;
    wr(A_CTRL, 8'h00);

    // mask
    wr(A_MASK, 8'h00);
    load_count(16'd2);
    wr(A_CTRL, 8'h03);
    repeat (6) @(negedge clk);
    check("R9 masked irq stays high", irq_no, 1);
    wr(A_MASK, 8'h01);
    check("R9 unmasked irq low", irq_no, 0);
    rd_stat(s); check("R9 flag seen under mask", s, 1);
    check("R9 irq high after read", irq_no, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule